// File: doc/BRIEF.md
# Framed Serial Audio Port with Receive Autobuffer

This block receives a synchronous, time-division multiplexed serial stream and sends one back. It has a bit clock, a receive data line and a frame marker. Each frame carries three 16-bit slots in a fixed order: a status/control word, then the left channel, then the right channel. The port gathers the bits of each slot into a word without any processor involvement and writes the word into a three-entry receive buffer. The buffer entry matches the slot position, so entry 1 holds left data and entry 2 holds right data. Over the same slots, it shifts out the contents of a three-entry transmit buffer on the transmit data line.

The processor is interrupted according to a mode input. In block mode it gets one pulse per completed frame, raised only after all three words have landed. In per-word mode it gets one pulse for every word. If a frame marker arrives while a frame is still incomplete, the slot sequence restarts and a framing-error pulse is raised.

All serial inputs are brought into the system clock domain through synchronizers. Bit-clock edges are detected in that domain.

Top module: `tdm_autobuf_port`

## Requirements
- R1: After reset, rxIrq, frameErr and txDataOut are 0, and every receive buffer entry reads 0.
- R2: rxFsyncIn is sampled on each rising edge of sclkIn, and a frame starts at a rising edge where it is 1. The following 48 rising edges sample rxDataIn as three 16-bit words, most significant bit first. These words are written to receive entries 0, 1 and 2 in that order.
- R3: With irqPerWord = 0, rxIrq pulses high for exactly one clk cycle once per frame, after the third word has been written.
- R4: With irqPerWord = 1, rxIrq pulses once per received word. When each pulse occurs, the entry for that slot already holds the new word.
- R5: Transmit entries 0, 1 and 2 are sent MSB first in slots 0, 1 and 2. txDataOut changes only after a falling edge of sclkIn, so it is stable at the rising edge where the receiver samples it.
- R6: Outside a frame (after the third word and before the next frame marker), txDataOut is 0.
- R7: A frame marker that arrives before all three words of the current frame have completed does the following: it pulses frameErr, raises no block-mode interrupt for the partial frame, and restarts reception at slot 0. A frame that completes normally raises no frameErr.
- R8: Bits clocked in while no frame is in progress change no receive entry and raise no interrupt.
- R9: Reading receive address 3, which lies past the last entry, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial bit clock (asynchronous to clk) |
| rxDataIn | input | 1 | Serial receive data |
| rxFsyncIn | input | 1 | Frame marker, high for the bit before slot 0 MSB |
| irqPerWord | input | 1 | 1: interrupt per word, 0: interrupt per frame |
| txWrEn | input | 1 | Write strobe for the transmit buffer |
| txWrAddr | input | 2 | Transmit buffer entry to write |
| txWrData | input | 16 | Word written into the transmit buffer |
| rxRdAddr | input | 2 | Receive buffer entry to read |
| rxRdData | output | 16 | Receive buffer entry contents |
| txDataOut | output | 1 | Serial transmit data |
| rxIrq | output | 1 | Receive interrupt pulse |
| frameErr | output | 1 | Framing-error pulse |

## Verification
The assertions rely on these assumptions about the inputs:
- Each half period of sclkIn lasts several clk cycles, so bit-clock edges are never closer together than the synchronizer latency.
- rxDataIn and rxFsyncIn change only while sclkIn is low.
- irqPerWord is held constant for the whole of a frame.

The stimulus meets these assumptions as follows. The bit clock is generated with a six-cycle half period. Data and marker are changed only at the start of the low phase. The mode is switched only between frames. The transmit line is sampled just before each rising edge, which is the point where a receiving codec would latch it.

// File: rtl/tdm_autobuf_pkg.sv
package tdm_autobuf_pkg;
  parameter int WORD_W = 16;
  parameter int SLOTS  = 3;
  parameter int SYNC_STAGES = 2;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int BIT_W  = $clog2(WORD_W);

  // Strobes from the control to the datapath
  typedef struct packed {
    logic              shiftEn;  // rising bit clock inside a frame
    logic              bitIn;    // synchronized data bit
    logic              wordWr;   // last bit of a slot: commit the word
    logic [SLOT_W-1:0] slot;     // current slot index
    logic              txUpd;    // falling bit clock: update tx line
    logic              txOn;     // a frame is in progress
    logic [BIT_W-1:0]  txBit;    // bit index inside the slot, 0 = MSB
  } strb_t;
endpackage

// File: rtl/tdm_autobuf_ctrl.sv
module tdm_autobuf_ctrl
  import tdm_autobuf_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  sclkIn,
  input  logic  rxDataIn,
  input  logic  rxFsyncIn,
  input  logic  irqPerWord,
  output strb_t st,
  output logic  rxIrq,
  output logic  frameErr
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SYNC_STAGES-1:0] sclkSync, dataSync, fsSync;
  logic sclkPrev;
  logic active;
  logic [SLOT_W-1:0] slotIdx;
  logic [BIT_W-1:0]  bitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      dataSync <= '0;
      fsSync   <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      dataSync <= {dataSync[SYNC_STAGES-2:0], rxDataIn};
      fsSync   <= {fsSync[SYNC_STAGES-2:0], rxFsyncIn};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  logic riseEdge, fallEdge, fsNow, bitNow;
  assign riseEdge = sclkSync[SYNC_STAGES-1] & ~sclkPrev;
  assign fallEdge = ~sclkSync[SYNC_STAGES-1] & sclkPrev;
  assign fsNow    = fsSync[SYNC_STAGES-1];
  assign bitNow   = dataSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      slotIdx  <= '0;
      bitIdx   <= '0;
      rxIrq    <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxIrq    <= 1'b0;
      frameErr <= 1'b0;
      if (riseEdge) begin
        if (fsNow) begin
          frameErr <= active;
          active   <= 1'b1;
          slotIdx  <= '0;
          bitIdx   <= '0;
        end else if (active) begin
          if (bitIdx == LAST_BIT) begin
            bitIdx <= '0;
            if (irqPerWord) rxIrq <= 1'b1;
            if (slotIdx == LAST_SLOT) begin
              active  <= 1'b0;
              slotIdx <= '0;
              if (!irqPerWord) rxIrq <= 1'b1;
            end else begin
              slotIdx <= slotIdx + 1'b1;
            end
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    st.shiftEn = riseEdge & ~fsNow & active;
    st.bitIn   = bitNow;
    st.wordWr  = riseEdge & ~fsNow & active & (bitIdx == LAST_BIT);
    st.slot    = slotIdx;
    st.txUpd   = fallEdge;
    st.txOn    = active;
    st.txBit   = bitIdx;
  end

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);                                                    // R3
  AST_BLOCK_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq && !irqPerWord) |-> !active);                                  // R3
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(slotIdx) < SLOTS);                                               // R2
  AST_ERR_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (active && slotIdx == '0 && bitIdx == '0));              // R7
endmodule

// File: rtl/tdm_autobuf_data.sv
module tdm_autobuf_data
  import tdm_autobuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             st,
  input  logic              txWrEn,
  input  logic [SLOT_W-1:0] txWrAddr,
  input  logic [WORD_W-1:0] txWrData,
  input  logic [SLOT_W-1:0] rxRdAddr,
  output logic [WORD_W-1:0] rxRdData,
  output logic              txDataOut
);
  localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] rxBuf [SLOTS];
  logic [WORD_W-1:0] txBuf [SLOTS];
  logic [WORD_W-1:0] nextWord;

  assign nextWord = {shiftReg[WORD_W-2:0], st.bitIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      for (int i = 0; i < SLOTS; i++) rxBuf[i] <= '0;
    end else if (st.shiftEn) begin
      shiftReg <= nextWord;
      if (st.wordWr && int'(st.slot) < SLOTS) rxBuf[st.slot] <= nextWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) txBuf[i] <= '0;
    end else if (txWrEn && int'(txWrAddr) < SLOTS) begin
      txBuf[txWrAddr] <= txWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txDataOut <= 1'b0;
    end else if (st.txUpd) begin
      if (st.txOn && int'(st.slot) < SLOTS) txDataOut <= txBuf[st.slot][MSB_IDX - st.txBit];
      else txDataOut <= 1'b0;
    end
  end

  assign rxRdData = (int'(rxRdAddr) < SLOTS) ? rxBuf[rxRdAddr] : '0;

  AST_TX_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !st.txUpd |=> $stable(txDataOut));                                    // R5
  AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (st.txUpd && !st.txOn) |=> !txDataOut);                               // R6
endmodule

// File: rtl/tdm_autobuf_port.sv
module tdm_autobuf_port
  import tdm_autobuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              rxDataIn,
  input  logic              rxFsyncIn,
  input  logic              irqPerWord,
  input  logic              txWrEn,
  input  logic [SLOT_W-1:0] txWrAddr,
  input  logic [WORD_W-1:0] txWrData,
  input  logic [SLOT_W-1:0] rxRdAddr,
  output logic [WORD_W-1:0] rxRdData,
  output logic              txDataOut,
  output logic              rxIrq,
  output logic              frameErr
);
  strb_t strobes;

  tdm_autobuf_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .rxDataIn(rxDataIn),
    .rxFsyncIn(rxFsyncIn), .irqPerWord(irqPerWord), .st(strobes),
    .rxIrq(rxIrq), .frameErr(frameErr)
  );

  tdm_autobuf_data data_i (
    .clk(clk), .rstN(rstN), .st(strobes), .txWrEn(txWrEn),
    .txWrAddr(txWrAddr), .txWrData(txWrData), .rxRdAddr(rxRdAddr),
    .rxRdData(rxRdData), .txDataOut(txDataOut)
  );
endmodule

// File: tb/tdm_autobuf_port_tb_top.sv
module tdm_autobuf_port_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sclk, rxd, fs, perWord, txWrEn;
  logic [1:0] txWrAddr, rxRdAddr;
  logic [15:0] txWrData, rxRdData;
  logic txd, irq, ferr;

  int checks = 0, errors = 0, irqCnt = 0, errCnt = 0;

  tdm_autobuf_port dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .rxDataIn(rxd), .rxFsyncIn(fs),
    .irqPerWord(perWord), .txWrEn(txWrEn), .txWrAddr(txWrAddr),
    .txWrData(txWrData), .rxRdAddr(rxRdAddr), .rxRdData(rxRdData),
    .txDataOut(txd), .rxIrq(irq), .frameErr(ferr)
  );

  always @(posedge clk) begin
    if (irq) irqCnt++;
    if (ferr) errCnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readRx(input logic [1:0] a, output logic [15:0] d);
    rxRdAddr = a;
    #1 d = rxRdData;
  endtask

  task automatic sendBit(input logic f, input logic d, output logic txs);
    rxd = d;
    fs  = f;
    repeat (HALF) @(negedge clk);
    txs  = txd;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic loadTx(input logic [15:0] t0, input logic [15:0] t1, input logic [15:0] t2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      txWrEn = 1'b1;
      txWrAddr = 2'(i);
      txWrData = (i == 0) ? t0 : (i == 1) ? t1 : t2;
    end
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic runFrame(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                          input logic [15:0] t0, input logic [15:0] t1, input logic [15:0] t2,
                          input logic mode, input int expErr);
    logic [15:0] words [3];
    logic [15:0] txw [3];
    logic [15:0] cap [3];
    logic [15:0] rd;
    logic tb;
    int baseIrq, baseErr;
    words[0] = w0; words[1] = w1; words[2] = w2;
    txw[0] = t0; txw[1] = t1; txw[2] = t2;
    perWord = mode;
    loadTx(t0, t1, t2);
    baseIrq = irqCnt;
    baseErr = errCnt;
    sendBit(1'b1, 1'b0, tb);
    for (int s = 0; s < 3; s++) begin
      for (int b = 15; b >= 0; b--) begin
        sendBit(1'b0, words[s][b], tb);
        cap[s][b] = tb;
      end
      if (mode) begin
        repeat (2) @(negedge clk);
        readRx(2'(s), rd);
        chk("R4 entry on word pulse", 32'(rd), 32'(words[s]));
        chk("R4 pulse count per word", 32'(irqCnt - baseIrq), 32'(s + 1));
      end
    end
    repeat (4) @(negedge clk);
    if (!mode) chk("R3 one pulse per frame", 32'(irqCnt - baseIrq), 32'd1);
    for (int s = 0; s < 3; s++) begin
      readRx(2'(s), rd);
      chk("R2 received entry", 32'(rd), 32'(words[s]));
      chk("R5 transmitted slot", 32'(cap[s]), 32'(txw[s]));
    end
    chk("R7 frame error count", 32'(errCnt - baseErr), 32'(expErr));
    baseIrq = irqCnt;
    sendBit(1'b0, 1'b1, tb);
    chk("R6 idle tx low", 32'(tb), 32'd0);
    sendBit(1'b0, 1'b1, tb);
    repeat (4) @(negedge clk);
    chk("R8 no pulse from stray bits", 32'(irqCnt - baseIrq), 32'd0);
    readRx(2'd2, rd);
    chk("R8 entry unchanged by stray bits", 32'(rd), 32'(w2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd, w0, w1, w2;
    logic tb;
    int baseIrq, baseErr;
    rstN = 1'b0; sclk = 1'b0; rxd = 1'b0; fs = 1'b0; perWord = 1'b0;
    txWrEn = 1'b0; txWrAddr = '0; txWrData = '0; rxRdAddr = '0;
    repeat (5) @(negedge clk);
    chk("R1 irq at reset", 32'(irq), 32'd0);
    chk("R1 frameErr at reset", 32'(ferr), 32'd0);
    chk("R1 tx at reset", 32'(txd), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      readRx(2'(i), rd);
      chk("R1 entry zero after reset", 32'(rd), 32'd0);
    end

    // R8: stray bits before any frame marker
    baseIrq = irqCnt;
    for (int i = 0; i < 20; i++) sendBit(1'b0, 1'b1, tb);
    repeat (4) @(negedge clk);
    chk("R8 no pulse before frame", 32'(irqCnt - baseIrq), 32'd0);
    for (int i = 0; i < 3; i++) begin
      readRx(2'(i), rd);
      chk("R8 entry untouched before frame", 32'(rd), 32'd0);
    end

    // R2..R6 sweep over walking patterns, alternating interrupt mode
    for (int i = 0; i < 16; i++) begin
      w0 = 16'h1 << i;
      w1 = ~w0;
      w2 = 16'(i * 16'h1111) ^ 16'hA5C3;
      runFrame(w0, w1, w2, w2, w0 ^ 16'h0F0F, {w1[7:0], w1[15:8]}, 1'(i % 2), 0);
    end

    // R7: marker arrives partway through slot 1
    perWord = 1'b0;
    baseIrq = irqCnt;
    baseErr = errCnt;
    sendBit(1'b1, 1'b0, tb);
    for (int i = 0; i < 20; i++) sendBit(1'b0, 1'b1, tb);
    repeat (4) @(negedge clk);
    chk("R7 no block pulse for partial frame", 32'(irqCnt - baseIrq), 32'd0);
    chk("R7 no error before restart", 32'(errCnt - baseErr), 32'd0);
    readRx(2'd0, rd);
    chk("R2 first word of partial frame", 32'(rd), 32'hFFFF);
    runFrame(16'h1357, 16'h2468, 16'hBEEF, 16'h8001, 16'h7FFE, 16'hC3C3, 1'b0, 1);

    // R9: address past the last entry
    readRx(2'd3, rd);
    chk("R9 read beyond last entry", 32'(rd), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule